// File: doc/BRIEF.md
# Single-Bank Open-Row DRAM Command Sequencer

This block drives one DRAM bank and leaves a row open after each access. A request names a row, a column and a direction, and enters through a valid/ready handshake. The sequencer turns each request into the shortest legal series of bank commands: activate, read, write and precharge. A timer for each timing rule makes sure that no command goes out early. Commands come out on a registered port, one per memory clock. A read-beat strobe marks the memory clocks in which read data returns. A write strobe marks the memory clocks in which write data is taken.

When a request is accepted, the sequencer sorts it into one of three classes. A hit goes to the row that is already open and needs only a column command. An access to an idle bank needs an activate first. A conflict must close the open row, wait for precharge and then activate the new row. Each class has its own saturating counter, and the three counts are outputs of the block. The block holds one request at a time and serves requests strictly in order.

Top module: `bank_sched`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it falls, the outputs are as follows: cmd_code is 0 (no operation), req_ready is 1, rd_beat and wr_take are 0, and all three counters are 0. The bank holds no open row and every timer has expired.
- R2: A column command (cmd_code 2 = READ, 3 = WRITE) appears no sooner than T_RCD cycles after the ACTIVATE (cmd_code 1) that opened its row.
- R3: rd_beat is high for exactly BURST_BEATS/2 consecutive cycles, starting T_CL cycles after each READ. Each cycle carries two data beats.
- R4: A request to a row other than the open one causes a PRECHARGE (cmd_code 4) first. The next ACTIVATE comes no sooner than T_RP cycles after it. A column command is issued only while a row is open.
- R5: A PRECHARGE comes no sooner than T_RAS cycles after the ACTIVATE of the row it closes.
- R6: Two ACTIVATE commands are at least T_RC cycles apart. When T_RC is the binding limit, the latency of a conflict grows beyond its unloaded value.
- R7: Two column commands are at least BURST_BEATS/2 cycles apart.
- R8: A WRITE is issued only when rd_beat is low in its own cycle and in the cycle before, and no read beat is outstanding. wr_take is high for BURST_BEATS/2 cycles, starting in the WRITE cycle.
- R9: Each accepted request is classified as follows. It is idle if it is the first request since reset. It is a hit if its row equals the row of the previous accepted request. Otherwise it is a conflict. hit_count, idle_count and conflict_count each add one for their class and hold at their all-ones value.
- R10: The accept cycle is the cycle in which req_valid and req_ready are both high. When all timers have expired, the first read beat comes 2+T_CL cycles after the accept cycle for a hit. It comes 2+T_RCD+T_CL cycles after for an idle bank, and 2+T_RP+T_RCD+T_CL cycles after for a conflict.
- R11: req_ready is low while a request is held. Each column command carries the row, column and direction of the oldest accepted request, in acceptance order.
- R12: A reset in the middle of an access drops the held request and closes the row. The next request counts as idle and sees the idle latency, even if T_RC has not elapsed since the last ACTIVATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| cmd_code | output | 3 | 0 none, 1 activate, 2 read, 3 write, 4 precharge |
| cmd_row | output | ROW_W | Row carried with the command |
| cmd_col | output | COL_W | Column carried with a read or write |
| rd_beat | output | 1 | Read data returns in this cycle (two beats) |
| wr_take | output | 1 | Write data is taken in this cycle (two beats) |
| hit_count | output | CNT_W | Saturating count of row hits |
| idle_count | output | CNT_W | Saturating count of idle-bank accesses |
| conflict_count | output | CNT_W | Saturating count of row conflicts |

## Verification
The hardest case to reach from the ports is a conflict where the activate-to-activate limit, not precharge, sets the timing. That happens only when a new row is requested within a few dozen cycles of the previous activation. The stimulus creates it directly: it opens a row after a long quiet period, then sends a conflicting request as soon as ready returns, and checks the exact cycle of the first read beat. A write placed right behind a read, and a reset that lands while a conflict is being served, are forced the same way. Random traffic over three rows then mixes all three classes and drives the counters into saturation.

// File: rtl/bank_pkg.sv
package bank_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } bank_cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_CLOSE = 2'd2
  } bank_st_e;

  // access classes, also the counter index
  localparam int CLS_HIT  = 0;
  localparam int CLS_IDLE = 1;
  localparam int CLS_CONF = 2;

  // timer slots
  localparam int TM_RCD = 0;
  localparam int TM_RAS = 1;
  localparam int TM_RC  = 2;
  localparam int TM_RP  = 3;
  localparam int TM_CCD = 4;
  localparam int TM_NUM = 5;

endpackage

// File: rtl/bank_cd_timer.sv
module bank_cd_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= value;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/bank_sat_ctr.sv
module bank_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                        count <= '0;
    else if (inc && count != '1)    count <= count + W'(1);
  end
endmodule

// File: rtl/bank_sched.sv
module bank_sched
  import bank_pkg::*;
#(
  parameter int ROW_W       = 14,
  parameter int COL_W       = 10,
  parameter int T_CL        = 15,
  parameter int T_RCD       = 15,
  parameter int T_RP        = 15,
  parameter int T_RAS       = 36,
  parameter int T_RC        = 54,
  parameter int BURST_BEATS = 8,
  parameter int CNT_W       = 16,
  parameter int TW          = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic [2:0]       cmd_code,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             rd_beat,
  output logic             wr_take,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] idle_count,
  output logic [CNT_W-1:0] conflict_count
);
  localparam int BCLK = BURST_BEATS / 2;
  localparam int SRW  = T_CL + BCLK;
  localparam int WLW  = $clog2(BCLK + 1);
  localparam logic [SRW-1:0] RD_MASK = {{BCLK{1'b1}}, {T_CL{1'b0}}};

  bank_st_e          st;
  logic [ROW_W-1:0]  open_row;
  logic              pend_v, pend_wr;
  logic [ROW_W-1:0]  pend_row;
  logic [COL_W-1:0]  pend_col;
  logic [SRW-1:0]    rd_pipe;
  logic [WLW-1:0]    wr_left;
  bank_cmd_e         nxt;

  // ---------------- timing rule timers ----------------
  logic [TM_NUM-1:0] t_load, t_done;
  logic [TW-1:0]     t_val [TM_NUM];

  assign t_val[TM_RCD] = TW'(T_RCD - 1);
  assign t_val[TM_RAS] = TW'(T_RAS - 1);
  assign t_val[TM_RC]  = TW'(T_RC - 1);
  assign t_val[TM_RP]  = TW'(T_RP - 1);
  assign t_val[TM_CCD] = TW'(BCLK - 1);

  assign t_load[TM_RCD] = (nxt == CMD_ACT);
  assign t_load[TM_RAS] = (nxt == CMD_ACT);
  assign t_load[TM_RC]  = (nxt == CMD_ACT);
  assign t_load[TM_RP]  = (nxt == CMD_PRE);
  assign t_load[TM_CCD] = (nxt == CMD_RD) || (nxt == CMD_WR);

  for (genvar i = 0; i < TM_NUM; i++) begin : g_tmr
    bank_cd_timer #(.W(TW)) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .load   (t_load[i]),
      .value  (t_val[i]),
      .expired(t_done[i])
    );
  end

  // ---------------- request intake and classification ----------------
  logic       acc;
  logic [1:0] cls;

  assign req_ready = !pend_v;
  assign acc       = req_valid && req_ready;

  always_comb begin
    if (st == BK_OPEN && req_row == open_row) cls = 2'(CLS_HIT);
    else if (st == BK_IDLE)                    cls = 2'(CLS_IDLE);
    else                                       cls = 2'(CLS_CONF);
  end

  logic [CNT_W-1:0] cnt_arr [3];
  for (genvar k = 0; k < 3; k++) begin : g_cnt
    bank_sat_ctr #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .inc  (acc && cls == 2'(k)),
      .count(cnt_arr[k])
    );
  end
  assign hit_count      = cnt_arr[CLS_HIT];
  assign idle_count     = cnt_arr[CLS_IDLE];
  assign conflict_count = cnt_arr[CLS_CONF];

  // ---------------- command choice ----------------
  always_comb begin
    nxt = CMD_NOP;
    if (pend_v) begin
      unique case (st)
        BK_IDLE, BK_CLOSE: begin
          if (t_done[TM_RC] && t_done[TM_RP]) nxt = CMD_ACT;
        end
        BK_OPEN: begin
          if (pend_row == open_row) begin
            if (t_done[TM_RCD] && t_done[TM_CCD] &&
                (!pend_wr || rd_pipe == '0))
              nxt = pend_wr ? CMD_WR : CMD_RD;
          end else if (t_done[TM_RAS] && t_done[TM_CCD]) begin
            nxt = CMD_PRE;
          end
        end
        default: nxt = CMD_NOP;
      endcase
    end
  end

  // ---------------- bank state and registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= BK_IDLE;
      open_row <= '0;
      pend_v   <= 1'b0;
      pend_wr  <= 1'b0;
      pend_row <= '0;
      pend_col <= '0;
      cmd_code <= 3'(CMD_NOP);
      cmd_row  <= '0;
      cmd_col  <= '0;
      rd_pipe  <= '0;
      wr_left  <= '0;
    end else begin
      if (acc) begin
        pend_v   <= 1'b1;
        pend_wr  <= req_write;
        pend_row <= req_row;
        pend_col <= req_col;
      end

      unique case (nxt)
        CMD_ACT: begin
          st       <= BK_OPEN;
          open_row <= pend_row;
        end
        CMD_PRE: st <= BK_CLOSE;
        CMD_RD, CMD_WR: pend_v <= 1'b0;
        default: if (st == BK_CLOSE && t_done[TM_RP]) st <= BK_IDLE;
      endcase

      cmd_code <= 3'(nxt);
      cmd_row  <= (nxt == CMD_NOP) ? '0 : ((nxt == CMD_PRE) ? open_row : pend_row);
      cmd_col  <= (nxt == CMD_RD || nxt == CMD_WR) ? pend_col : '0;

      rd_pipe  <= (rd_pipe >> 1) | ((nxt == CMD_RD) ? RD_MASK : '0);

      if (nxt == CMD_WR)      wr_left <= WLW'(BCLK);
      else if (wr_left != '0) wr_left <= wr_left - WLW'(1);
    end
  end

  assign rd_beat = rd_pipe[0];
  assign wr_take = (wr_left != '0);

endmodule

// File: rtl/bank_sched_chk.sv
module bank_sched_chk #(
  parameter int T_RCD       = 15,
  parameter int T_RP        = 15,
  parameter int T_RAS       = 36,
  parameter int T_RC        = 54,
  parameter int BURST_BEATS = 8,
  parameter int CNT_W       = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic [2:0]       cmd_code,
  input logic             rd_beat,
  input logic             wr_take,
  input logic [CNT_W-1:0] hit_count
);
  localparam logic [15:0] L_RCD = 16'(T_RCD);
  localparam logic [15:0] L_RP  = 16'(T_RP);
  localparam logic [15:0] L_RAS = 16'(T_RAS);
  localparam logic [15:0] L_RC  = 16'(T_RC);
  localparam logic [15:0] L_CCD = 16'(BURST_BEATS / 2);

  logic [15:0] since_act, since_pre, since_col;
  logic        seen_act, seen_pre, seen_col;
  logic        is_col;

  assign is_col = (cmd_code == 3'd2) || (cmd_code == 3'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_act <= '1; since_pre <= '1; since_col <= '1;
      seen_act  <= 1'b0; seen_pre <= 1'b0; seen_col <= 1'b0;
    end else begin
      if (cmd_code == 3'd1) begin since_act <= 16'd1; seen_act <= 1'b1; end
      else if (since_act != '1) since_act <= since_act + 16'd1;
      if (cmd_code == 3'd4) begin since_pre <= 16'd1; seen_pre <= 1'b1; end
      else if (since_pre != '1) since_pre <= since_pre + 16'd1;
      if (is_col) begin since_col <= 16'd1; seen_col <= 1'b1; end
      else if (since_col != '1) since_col <= since_col + 16'd1;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (cmd_code == 3'd0 && req_ready && !rd_beat && !wr_take));

  p_rcd_gap_r2: assert property (@(posedge clk) disable iff (rst)
    is_col |-> (seen_act && since_act >= L_RCD));

  p_rp_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == 3'd1 && seen_pre) |-> since_pre >= L_RP);

  p_ras_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == 3'd4) |-> (seen_act && since_act >= L_RAS));

  p_rc_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == 3'd1 && seen_act) |-> since_act >= L_RC);

  p_col_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (is_col && seen_col) |-> since_col >= L_CCD);

  p_wr_bus_free_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == 3'd3) |-> (!rd_beat && wr_take));

  p_hits_monotone_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> hit_count >= $past(hit_count));

endmodule

bind bank_sched bank_sched_chk #(
  .T_RCD      (T_RCD),
  .T_RP       (T_RP),
  .T_RAS      (T_RAS),
  .T_RC       (T_RC),
  .BURST_BEATS(BURST_BEATS),
  .CNT_W      (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_ready(req_ready),
  .cmd_code (cmd_code),
  .rd_beat  (rd_beat),
  .wr_take  (wr_take),
  .hit_count(hit_count)
);

// File: tb/sim_bank_sched.sv
`timescale 1ns/1ps
module sim_bank_sched;
  localparam int ROW_W = 14, COL_W = 10;
  localparam int CL = 15, RCD = 15, RP = 15, RAS = 36, RC = 54;
  localparam int BB = 8, BCLK = 4, CW = 4, CMAX = 15;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ready, rd_beat, wr_take;
  logic [2:0] cmd_code;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic [CW-1:0] hit_count, idle_count, conflict_count;

  always #2 clk = ~clk;   // 250 MHz

  bank_sched #(.ROW_W(ROW_W), .COL_W(COL_W), .T_CL(CL), .T_RCD(RCD), .T_RP(RP),
               .T_RAS(RAS), .T_RC(RC), .BURST_BEATS(BB), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .cmd_code(cmd_code), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .rd_beat(rd_beat), .wr_take(wr_take), .hit_count(hit_count),
    .idle_count(idle_count), .conflict_count(conflict_count));

  int nchk = 0, nerr = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct { bit wr; int row; int col; } rq_t;
  rq_t q[$];
  bit  m_valid = 0;
  int  m_row = 0, e_hit = 0, e_idle = 0, e_conf = 0;
  bit  exp_rd [64];
  bit  exp_wr [64];
  bit  started = 0, have_act = 0, have_pre = 0, have_col = 0, bopen_v = 0, prev_rd = 0;
  int  last_act = 0, last_pre = 0, last_col = 0, brow = 0;

  function automatic int sat_inc(input int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  function automatic int unloaded_lat(input int cls); // 0 hit, 1 idle, 2 conflict
    case (cls)
      0: return 2 + CL;
      1: return 2 + RCD + CL;
      default: return 2 + RP + RCD + CL;
    endcase
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic clear_model();
    q.delete();
    m_valid = 0; e_hit = 0; e_idle = 0; e_conf = 0;
    for (int i = 0; i < 64; i++) begin exp_rd[i] = 0; exp_wr[i] = 0; end
    have_act = 0; have_pre = 0; have_col = 0; bopen_v = 0; prev_rd = 0;
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    #2;
    if (!rst && started) begin
      case (cmd_code)
        3'd1: begin
          if (have_act) chk(cyc - last_act >= RC, "R6 act-to-act", cyc - last_act, RC);
          if (have_pre) chk(cyc - last_pre >= RP, "R4 pre-to-act", cyc - last_pre, RP);
          chk(!bopen_v, "R4 act with row open", bopen_v, 0);
          bopen_v = 1; brow = int'(cmd_row); last_act = cyc; have_act = 1;
        end
        3'd4: begin
          chk(bopen_v, "R4 pre without open row", bopen_v, 1);
          chk(cyc - last_act >= RAS, "R5 act-to-pre", cyc - last_act, RAS);
          bopen_v = 0; last_pre = cyc; have_pre = 1;
        end
        3'd2, 3'd3: begin
          chk(bopen_v, "R4 column with no open row", bopen_v, 1);
          chk(cyc - last_act >= RCD, "R2 act-to-column", cyc - last_act, RCD);
          if (have_col) chk(cyc - last_col >= BCLK, "R7 column spacing", cyc - last_col, BCLK);
          if (q.size() == 0) chk(0, "R11 column without request", 1, 0);
          else begin
            rq_t f;
            f = q.pop_front();
            chk(int'(cmd_row) == f.row && brow == f.row, "R11 row", int'(cmd_row), f.row);
            chk(int'(cmd_col) == f.col, "R11 column", int'(cmd_col), f.col);
            chk((cmd_code == 3'd3) == f.wr, "R11 direction", int'(cmd_code), f.wr ? 3 : 2);
          end
          if (cmd_code == 3'd2) begin
            for (int i = 0; i < BCLK; i++) exp_rd[(cyc + CL + i) % 64] = 1;
          end else begin
            chk(!rd_beat && !prev_rd, "R8 write over read burst", rd_beat | prev_rd, 0);
            for (int i = 0; i < 64; i++)
              if (exp_rd[i]) chk(0, "R8 read beat outstanding at write", 1, 0);
            for (int i = 0; i < BCLK; i++) exp_wr[(cyc + i) % 64] = 1;
          end
          last_col = cyc; have_col = 1;
        end
        default: ;
      endcase
      if (rd_beat || exp_rd[cyc % 64])
        chk(rd_beat == exp_rd[cyc % 64], "R3 read beat", rd_beat, exp_rd[cyc % 64]);
      if (wr_take || exp_wr[cyc % 64])
        chk(wr_take == exp_wr[cyc % 64], "R8 write take", wr_take, exp_wr[cyc % 64]);
      exp_rd[cyc % 64] = 0;
      exp_wr[cyc % 64] = 0;
      prev_rd = rd_beat;
    end
  end

  // ---------------- driver tasks ----------------
  task automatic send(input bit wr, input int row, input int col, output int tacc, output int cls);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_row = ROW_W'(row); req_col = COL_W'(col);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    tacc = cyc;
    if (!m_valid) begin cls = 1; e_idle = sat_inc(e_idle); end
    else if (row == m_row) begin cls = 0; e_hit = sat_inc(e_hit); end
    else begin cls = 2; e_conf = sat_inc(e_conf); end
    m_valid = 1; m_row = row;
    q.push_back('{wr, row, col});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_beat(output int t);
    while (!rd_beat) @(negedge clk);
    t = cyc;
  endtask

  task automatic check_counts(input string tag);
    chk(int'(hit_count) == e_hit, {"R9 hit count ", tag}, int'(hit_count), e_hit);
    chk(int'(idle_count) == e_idle, {"R9 idle count ", tag}, int'(idle_count), e_idle);
    chk(int'(conflict_count) == e_conf, {"R9 conflict count ", tag}, int'(conflict_count), e_conf);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #3;
    chk(cmd_code == 3'd0, "R1 cmd after reset", int'(cmd_code), 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(!rd_beat && !wr_take, "R1 strobes after reset", rd_beat | wr_take, 0);
    check_counts("after reset R1");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R11 watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int t0, t1, tb, cls, a, exp_t;
    void'($urandom(32'd4242));
    clear_model();
    repeat (4) @(negedge clk);
    started = 1;
    do_reset();

    // R10: unloaded latencies of the three classes
    repeat (100) @(negedge clk);
    send(0, 5, 3, t0, cls);
    wait_beat(tb);
    chk(cls == 1, "R9 first access is idle", cls, 1);
    chk(tb - t0 == unloaded_lat(1), "R10 idle latency", tb - t0, unloaded_lat(1));
    repeat (100) @(negedge clk);
    send(0, 5, 17, t0, cls);
    wait_beat(tb);
    chk(tb - t0 == unloaded_lat(0), "R10 hit latency", tb - t0, unloaded_lat(0));
    repeat (100) @(negedge clk);
    send(0, 9, 40, t0, cls);
    wait_beat(tb);
    chk(tb - t0 == unloaded_lat(2), "R10 conflict latency", tb - t0, unloaded_lat(2));
    repeat (100) @(negedge clk);
    check_counts("directed R9");

    // R6: conflict right after an activation, activate-to-activate binds
    send(0, 700, 1, t0, cls);
    a = t0 + 2 + RP;
    send(0, 9, 2, t1, cls);
    wait_beat(tb);
    while (rd_beat) @(negedge clk);
    wait_beat(tb);
    exp_t = max2(max2(t1 + 2, a + RAS) + RP, a + RC) + RCD + CL;
    chk(tb == exp_t, "R6 conflict stretched by act-to-act", tb, exp_t);

    // R8: write queued right behind a read to the same row
    repeat (100) @(negedge clk);
    send(0, 9, 5, t0, cls);
    send(1, 9, 6, t1, cls);
    repeat (80) @(negedge clk);
    chk(q.size() == 0, "R11 all requests served", q.size(), 0);

    // R12: reset while a conflict is in progress
    send(0, 5, 8, t0, cls);
    repeat (5) @(negedge clk);
    do_reset();
    send(0, 5, 9, t0, cls);
    wait_beat(tb);
    chk(tb - t0 == unloaded_lat(1), "R12 idle latency after reset", tb - t0, unloaded_lat(1));
    chk(cls == 1, "R12 class after reset", cls, 1);
    repeat (40) @(negedge clk);
    check_counts("R12");

    // random traffic over three rows, drives counters to saturation
    for (int n = 0; n < 250; n++) begin
      int sel, gap;
      sel = $urandom % 3;
      gap = $urandom % 4;
      repeat (gap) @(negedge clk);
      send(($urandom % 3) == 0, (sel == 0) ? 5 : ((sel == 1) ? 9 : 700),
           $urandom % 1024, t0, cls);
    end
    repeat (200) @(negedge clk);
    chk(q.size() == 0, "R11 random traffic drained", q.size(), 0);
    check_counts("random R9");
    chk(int'(hit_count) == CMAX, "R9 hit counter saturated", int'(hit_count), CMAX);

    finish_run();
  end
endmodule